// File: doc/BRIEF.md
# Dual-Dispatch Completion Queue Controller

This block keeps the dispatch and retirement books of a small superscalar core whose results complete in program order. An upstream two-entry dispatch buffer presents up to two instruction tokens per cycle. Slot 0 always holds the older token. Each token carries a tag, an execution-unit identifier and a destination flag. The controller decides which tokens leave the buffer in the current cycle. An accepted token takes one rename register and one completion-queue slot. Tokens are accepted strictly in order.

Execution units report finished work with a strobe and the completion-queue index of the entry. Reports may come back in any order. The controller retires finished entries from the head of the queue, at most two per cycle. It presents the retired tags and destination flags, and returns the resources to the two free pools.

Completion-queue indices are handed out in sequence. The first token accepted after reset gets index 0, the next gets index 1, and so on up to the queue depth minus one, after which the sequence wraps to 0. The execution side uses these indices when it reports a finish.

Top module: `cq_dispatch_ctrl`

## Requirements
- R1: After reset, the rename pool reports 6 free registers and the completion queue reports 8 free slots. No token is accepted and no entry retires until tokens are presented.
- R2: Slot 0 is accepted (`disp_acc_o[0]`) when it is valid and both pools have at least one free entry. Slot 1 is accepted (`disp_acc_o[1]`) only in the same cycle as slot 0, and only when both pools have at least two free entries.
- R3: When a pool cannot cover the oldest waiting token, that token stalls and so does every token behind it. A valid slot 1 is never accepted while slot 0 is not accepted.
- R4: When the two slots carry the same unit identifier, slot 1 is not accepted in that cycle.
- R5: Each accepted token lowers both free counts by one at the next clock edge. Each retired entry raises both counts by one at the next clock edge. A freed entry is therefore allocatable in the cycle after its retirement, and not in the same cycle.
- R6: An entry retires only once it has finished and every older entry has retired. `ret_tag_o[7:0]` gives the tag of the oldest retiring entry, so tags leave in the order their tokens were accepted.
- R7: When the two oldest entries have both finished, both retire in the same cycle. `ret_vld_o` is then 2'b11 and `ret_tag_o[15:8]` holds the tag of the second entry.
- R8: Completion-queue indices are assigned in sequence from 0 after reset, wrapping after 7. A finish report whose index holds no live entry is ignored, and it does not mark a token that is later placed at that index.
- R9: While the head entry has not finished, nothing retires, even if younger entries have finished. If the head stays unfinished long enough, the pools run dry and dispatch stalls.
- R10: `ret_dst_o[k]` carries the destination flag that came with the token retiring on lane k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_vld_i | input | 2 | Dispatch-buffer slot valid; slot 0 is older |
| slot_tag_i | input | 16 | Tags of slot 0 [7:0] and slot 1 [15:8] |
| slot_unit_i | input | 6 | Target unit identifiers of slot 0 [2:0] and slot 1 [5:3] |
| slot_dst_i | input | 2 | Destination flags of slot 0 and slot 1 |
| fin_vld_i | input | 2 | Finish report strobes, one per report port |
| fin_idx_i | input | 6 | Completion-queue index of each finish report, 3 bits per port |
| disp_acc_o | output | 2 | Per-slot dispatch accept for the current cycle |
| ret_vld_o | output | 2 | Retire valid; lane 0 is the oldest entry |
| ret_tag_o | output | 16 | Tags of the retiring entries, lane 0 in [7:0] |
| ret_dst_o | output | 2 | Destination flags of the retiring entries |
| ren_free_o | output | 3 | Free rename registers |
| cq_free_o | output | 4 | Free completion-queue slots |

## Verification
The first set of tests covers dispatch. Token pairs with equal and with distinct unit identifiers are applied, and the results tell the unit-conflict hold apart from a stall caused by the pools. The pools are then filled with no finishes, which separates a partial pair acceptance from a full stall. Finish reports are sent in reverse and in scattered order, and stray reports are sent to empty indices. These show that retirement waits for the head entry, that it pairs up when the two oldest entries have finished, and that freed resources come back exactly one cycle later. A long seeded random mix of token arrivals, unit collisions and finish bursts, with periods when no finishes arrive, is compared cycle by cycle against a reference queue model. A final drain confirms that every tag leaves in order and that both pools return to full.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int unsigned CQ_TAG_W = 8;

  typedef struct packed {
    logic                vld;
    logic                fin;
    logic                dst;
    logic [CQ_TAG_W-1:0] tag;
  } cq_ent_t;

  // population count of a two-bit vector
  function automatic logic [1:0] cnt2(input logic [1:0] v);
    return {v[1] & v[0], v[1] ^ v[0]};
  endfunction
endpackage

// File: rtl/cq_free_pool.sv
module cq_free_pool #(
  parameter  int unsigned SIZE = 6,
  localparam int unsigned CW   = $clog2(SIZE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    take_i,
  input  logic [1:0]    give_i,
  output logic [CW-1:0] free_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_o <= CW'(SIZE);
    else         free_o <= free_o - CW'(take_i) + CW'(give_i);
  end
endmodule

// File: rtl/cq_disp_arb.sv
module cq_disp_arb #(
  parameter int unsigned UNIT_W = 3
) (
  input  logic [1:0]          vld_i,
  input  logic [2*UNIT_W-1:0] unit_i,
  input  logic                room1_i,
  input  logic                room2_i,
  output logic [1:0]          acc_o
);
  logic same_unit;
  logic acc0;

  assign same_unit = unit_i[UNIT_W-1:0] == unit_i[2*UNIT_W-1:UNIT_W];
  assign acc0      = vld_i[0] & room1_i;
  // younger slot only rides along with the older one
  assign acc_o     = {acc0 & vld_i[1] & room2_i & ~same_unit, acc0};
endmodule

// File: rtl/cq_rob.sv
module cq_rob
  import cq_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  parameter  int unsigned FIN_N = 2,
  localparam int unsigned IW    = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            push_i,
  input  logic [2*CQ_TAG_W-1:0] push_tag_i,
  input  logic [1:0]            push_dst_i,
  input  logic [FIN_N-1:0]      fin_vld_i,
  input  logic [FIN_N*IW-1:0]   fin_idx_i,
  output logic [1:0]            ret_o,
  output logic [2*CQ_TAG_W-1:0] ret_tag_o,
  output logic [1:0]            ret_dst_o
);
  cq_ent_t       ent_q [DEPTH];
  cq_ent_t       ent_d [DEPTH];
  logic [IW-1:0] head_q, tail_q;
  logic [IW-1:0] head1, tail1;
  logic          ret0, ret1;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
  endfunction

  assign head1 = wrap_inc(head_q);
  assign tail1 = wrap_inc(tail_q);

  assign ret0      = ent_q[head_q].vld & ent_q[head_q].fin;
  assign ret1      = ret0 & ent_q[head1].vld & ent_q[head1].fin;
  assign ret_o     = {ret1, ret0};
  assign ret_tag_o = {ent_q[head1].tag, ent_q[head_q].tag};
  assign ret_dst_o = {ent_q[head1].dst, ent_q[head_q].dst};

  always_comb begin
    ent_d = ent_q;
    for (int f = 0; f < FIN_N; f++) begin
      if (fin_vld_i[f] && (int'(fin_idx_i[f*IW +: IW]) < DEPTH)
          && ent_q[fin_idx_i[f*IW +: IW]].vld)
        ent_d[fin_idx_i[f*IW +: IW]].fin = 1'b1;
    end
    if (ret0) ent_d[head_q].vld = 1'b0;
    if (ret1) ent_d[head1].vld  = 1'b0;
    if (push_i[0])
      ent_d[tail_q] = '{vld: 1'b1, fin: 1'b0, dst: push_dst_i[0],
                        tag: push_tag_i[CQ_TAG_W-1:0]};
    if (push_i[1])
      ent_d[tail1]  = '{vld: 1'b1, fin: 1'b0, dst: push_dst_i[1],
                        tag: push_tag_i[2*CQ_TAG_W-1:CQ_TAG_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      ent_q  <= ent_d;
      head_q <= ret1 ? wrap_inc(head1) : (ret0 ? head1 : head_q);
      tail_q <= push_i[1] ? wrap_inc(tail1) : (push_i[0] ? tail1 : tail_q);
    end
  end
endmodule

// File: rtl/cq_dispatch_ctrl.sv
module cq_dispatch_ctrl
  import cq_pkg::*;
#(
  parameter  int unsigned NUM_REN  = 6,
  parameter  int unsigned CQ_DEPTH = 8,
  parameter  int unsigned UNIT_W   = 3,
  parameter  int unsigned FIN_N    = 2,
  localparam int unsigned IDX_W    = $clog2(CQ_DEPTH),
  localparam int unsigned RFW      = $clog2(NUM_REN + 1),
  localparam int unsigned QFW      = $clog2(CQ_DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            slot_vld_i,
  input  logic [2*CQ_TAG_W-1:0] slot_tag_i,
  input  logic [2*UNIT_W-1:0]   slot_unit_i,
  input  logic [1:0]            slot_dst_i,
  input  logic [FIN_N-1:0]      fin_vld_i,
  input  logic [FIN_N*IDX_W-1:0] fin_idx_i,
  output logic [1:0]            disp_acc_o,
  output logic [1:0]            ret_vld_o,
  output logic [2*CQ_TAG_W-1:0] ret_tag_o,
  output logic [1:0]            ret_dst_o,
  output logic [RFW-1:0]        ren_free_o,
  output logic [QFW-1:0]        cq_free_o
);
  logic       room1, room2;
  logic [1:0] n_acc, n_ret;

  // pools seen here are last edge's values: frees from a retire show up one cycle later
  assign room1 = (ren_free_o != '0) && (cq_free_o != '0);
  assign room2 = (ren_free_o >= RFW'(2)) && (cq_free_o >= QFW'(2));

  cq_disp_arb #(.UNIT_W(UNIT_W)) u_arb (
    .vld_i   (slot_vld_i),
    .unit_i  (slot_unit_i),
    .room1_i (room1),
    .room2_i (room2),
    .acc_o   (disp_acc_o)
  );

  assign n_acc = cnt2(disp_acc_o);
  assign n_ret = cnt2(ret_vld_o);

  cq_free_pool #(.SIZE(NUM_REN)) u_ren_pool (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (n_acc),
    .give_i (n_ret),
    .free_o (ren_free_o)
  );

  cq_free_pool #(.SIZE(CQ_DEPTH)) u_slot_pool (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (n_acc),
    .give_i (n_ret),
    .free_o (cq_free_o)
  );

  cq_rob #(.DEPTH(CQ_DEPTH), .FIN_N(FIN_N)) u_rob (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (disp_acc_o),
    .push_tag_i (slot_tag_i),
    .push_dst_i (slot_dst_i),
    .fin_vld_i  (fin_vld_i),
    .fin_idx_i  (fin_idx_i),
    .ret_o      (ret_vld_o),
    .ret_tag_o  (ret_tag_o),
    .ret_dst_o  (ret_dst_o)
  );
endmodule

// File: rtl/cq_dispatch_ctrl_chk.sv
module cq_dispatch_ctrl_chk #(
  parameter  int unsigned NUM_REN  = 6,
  parameter  int unsigned CQ_DEPTH = 8,
  parameter  int unsigned UNIT_W   = 3,
  localparam int unsigned RFW      = $clog2(NUM_REN + 1),
  localparam int unsigned QFW      = $clog2(CQ_DEPTH + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          slot_vld_i,
  input logic [2*UNIT_W-1:0] slot_unit_i,
  input logic [1:0]          disp_acc_o,
  input logic [1:0]          ret_vld_o,
  input logic [RFW-1:0]      ren_free_o,
  input logic [QFW-1:0]      cq_free_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  a_r2_young_needs_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_acc_o[1] |-> disp_acc_o[0]);

  a_r2_acc_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_acc_o[0] |-> slot_vld_i[0]) and (disp_acc_o[1] |-> slot_vld_i[1]));

  a_r3_no_dispatch_when_dry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ren_free_o == '0) || (cq_free_o == '0)) |-> (disp_acc_o == 2'b00));

  a_r4_unit_conflict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_acc_o[1] |-> (slot_unit_i[UNIT_W-1:0] != slot_unit_i[2*UNIT_W-1:UNIT_W]));

  a_r7_retire_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_vld_o[1] |-> ret_vld_o[0]);

  a_r5_pools_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cq_free_o) - int'(ren_free_o)) == (int'(CQ_DEPTH) - int'(NUM_REN)));

  a_r5_free_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (int'(ren_free_o) == int'($past(ren_free_o))
                 - $countones($past(disp_acc_o)) + $countones($past(ret_vld_o))));

  a_r5_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ren_free_o) <= int'(NUM_REN));
endmodule

bind cq_dispatch_ctrl cq_dispatch_ctrl_chk #(
  .NUM_REN  (NUM_REN),
  .CQ_DEPTH (CQ_DEPTH),
  .UNIT_W   (UNIT_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slot_vld_i  (slot_vld_i),
  .slot_unit_i (slot_unit_i),
  .disp_acc_o  (disp_acc_o),
  .ret_vld_o   (ret_vld_o),
  .ren_free_o  (ren_free_o),
  .cq_free_o   (cq_free_o)
);

// File: tb/cq_dispatch_ctrl_tb_top.sv
`timescale 1ns/1ps
module cq_dispatch_ctrl_tb_top;
  localparam int NR = 6;
  localparam int QD = 8;
  localparam int UW = 3;
  localparam int FN = 2;
  localparam int IW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  slot_vld = '0;
  logic [15:0] slot_tag = '0;
  logic [5:0]  slot_unit = '0;
  logic [1:0]  slot_dst = '0;
  logic [1:0]  fin_vld = '0;
  logic [5:0]  fin_idx = '0;
  logic [1:0]  disp_acc, ret_vld, ret_dst;
  logic [15:0] ret_tag;
  logic [2:0]  ren_free;
  logic [3:0]  cq_free;

  always #2 clk = ~clk;

  cq_dispatch_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .slot_vld_i(slot_vld), .slot_tag_i(slot_tag), .slot_unit_i(slot_unit),
    .slot_dst_i(slot_dst), .fin_vld_i(fin_vld), .fin_idx_i(fin_idx),
    .disp_acc_o(disp_acc), .ret_vld_o(ret_vld), .ret_tag_o(ret_tag),
    .ret_dst_o(ret_dst), .ren_free_o(ren_free), .cq_free_o(cq_free)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // reference queue
  bit       m_vld [QD];
  bit       m_fin [QD];
  bit       m_dst [QD];
  bit [7:0] m_tag [QD];
  int       m_head = 0, m_tail = 0, m_cnt = 0;
  bit [7:0] exp_tag = '0;

  // dispatch buffer
  bit       b_vld [2];
  bit [7:0] b_tag [2];
  bit [2:0] b_unit [2];
  bit       b_dst [2];
  bit [7:0] next_tag = '0;
  bit       rnd_fill = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int qidx(input int k);
    return (m_head + k) % QD;
  endfunction

  task automatic load(input int s, input int unit, input int dst);
    b_vld[s]  = 1'b1;
    b_tag[s]  = next_tag;
    next_tag  = next_tag + 8'd1;
    b_unit[s] = 3'(unit);
    b_dst[s]  = dst[0];
  endtask

  task automatic shift_down();
    b_vld[0] = b_vld[1]; b_tag[0] = b_tag[1];
    b_unit[0] = b_unit[1]; b_dst[0] = b_dst[1];
    b_vld[1] = 1'b0;
  endtask

  task automatic step(input bit f0v, input int f0i, input bit f1v, input int f1i);
    int avail, h1;
    bit ea0, ea1, er0, er1;
    string la, lr;
    @(negedge clk);
    slot_vld  = {b_vld[1], b_vld[0]};
    slot_tag  = {b_tag[1], b_tag[0]};
    slot_unit = {b_unit[1], b_unit[0]};
    slot_dst  = {b_dst[1], b_dst[0]};
    fin_vld   = {f1v, f0v};
    fin_idx   = {3'(f1i), 3'(f0i)};
    #1;
    avail = (NR - m_cnt < QD - m_cnt) ? NR - m_cnt : QD - m_cnt;
    ea0 = b_vld[0] && avail >= 1;
    ea1 = ea0 && b_vld[1] && (b_unit[0] != b_unit[1]) && avail >= 2;
    h1  = (m_head + 1) % QD;
    er0 = m_vld[m_head] && m_fin[m_head];
    er1 = er0 && m_vld[h1] && m_fin[h1];
    la = (avail == 0) ? "R3" :
         (b_vld[0] && b_vld[1] && b_unit[0] == b_unit[1]) ? "R4" : "R2";
    lr = er1 ? "R7" : (m_vld[m_head] && !m_fin[m_head]) ? "R9" : "R6";
    chk(la, int'(disp_acc), int'({ea1, ea0}));
    chk(lr, int'(ret_vld), int'({er1, er0}));
    chk("R5", int'(ren_free), NR - m_cnt);
    chk("R5", int'(cq_free), QD - m_cnt);
    if (er0) begin
      chk("R6", int'(ret_tag[7:0]), int'(exp_tag));
      chk("R10", int'(ret_dst[0]), int'(m_dst[m_head]));
      exp_tag = exp_tag + 8'd1;
    end
    if (er1) begin
      chk("R7", int'(ret_tag[15:8]), int'(exp_tag));
      chk("R10", int'(ret_dst[1]), int'(m_dst[h1]));
      exp_tag = exp_tag + 8'd1;
    end
    // reference update for the coming edge
    if (f0v && m_vld[f0i]) m_fin[f0i] = 1'b1;
    if (f1v && m_vld[f1i]) m_fin[f1i] = 1'b1;
    if (er0) m_vld[m_head] = 1'b0;
    if (er1) m_vld[h1] = 1'b0;
    m_head = (m_head + int'(er0) + int'(er1)) % QD;
    if (ea0) begin
      m_vld[m_tail] = 1'b1; m_fin[m_tail] = 1'b0;
      m_dst[m_tail] = b_dst[0]; m_tag[m_tail] = b_tag[0];
      m_tail = (m_tail + 1) % QD;
    end
    if (ea1) begin
      m_vld[m_tail] = 1'b1; m_fin[m_tail] = 1'b0;
      m_dst[m_tail] = b_dst[1]; m_tag[m_tail] = b_tag[1];
      m_tail = (m_tail + 1) % QD;
    end
    m_cnt = m_cnt + int'(ea0) + int'(ea1) - int'(er0) - int'(er1);
    // buffer advance
    if (ea1) begin b_vld[0] = 1'b0; b_vld[1] = 1'b0; end
    else if (ea0) shift_down();
    if (!b_vld[0] && b_vld[1]) shift_down();
    if (rnd_fill) begin
      if (!b_vld[0] && $urandom_range(0, 3) != 0)
        load(0, $urandom_range(0, 3), $urandom_range(0, 1));
      if (b_vld[0] && !b_vld[1] && $urandom_range(0, 3) != 0)
        load(1, $urandom_range(0, 3), $urandom_range(0, 1));
    end
  endtask

  task automatic finish_heads();
    step(m_vld[qidx(0)], qidx(0), m_vld[qidx(1)], qidx(1));
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < QD; i++) begin m_vld[i] = 0; m_fin[i] = 0; m_dst[i] = 0; m_tag[i] = 0; end
    for (int s = 0; s < 2; s++) begin b_vld[s] = 0; b_tag[s] = 0; b_unit[s] = 0; b_dst[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    step(0, 0, 0, 0);
    chk("R1", int'(disp_acc), 0);
    chk("R1", int'(ret_vld), 0);
    chk("R1", int'(ren_free), NR);
    chk("R1", int'(cq_free), QD);

    // R8: stray finishes to empty indices 0 and 1, then allocate them
    step(1, 0, 1, 1);
    load(0, 2, 1); load(1, 3, 0);
    step(0, 0, 0, 0);
    chk("R2", int'(disp_acc), 3);
    step(0, 0, 0, 0);
    chk("R8", int'(ret_vld), 0);
    step(1, qidx(0), 1, qidx(1));
    step(0, 0, 0, 0);
    chk("R7", int'(ret_vld), 3);
    step(0, 0, 0, 0);
    chk("R5", int'(ren_free), NR);

    // R4: same unit pair, then fill to exhaustion (R3)
    load(0, 1, 1); load(1, 1, 0);
    step(0, 0, 0, 0);
    chk("R4", int'(disp_acc), 1);
    load(1, 2, 1);
    step(0, 0, 0, 0);
    load(0, 3, 0); load(1, 4, 1);
    step(0, 0, 0, 0);
    load(0, 5, 1); load(1, 6, 0);
    step(0, 0, 0, 0);
    chk("R3", int'(disp_acc), 1);
    step(0, 0, 0, 0);
    chk("R3", int'(disp_acc), 0);
    chk("R3", int'(ren_free), 0);

    // R9: younger finishes first, head blocks
    step(1, qidx(2), 0, 0);
    step(1, qidx(0), 0, 0);
    chk("R9", int'(ret_vld), 0);
    step(1, qidx(1), 0, 0);
    chk("R6", int'(ret_vld), 1);
    chk("R5", int'(ren_free), 0);
    chk("R5", int'(disp_acc), 0);
    step(0, 0, 0, 0);
    chk("R5", int'(ren_free), 1);
    chk("R5", int'(disp_acc), 1);
    chk("R7", int'(ret_vld), 3);
    repeat (8) finish_heads();

    // constrained random mix
    rnd_fill = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if ((i / 100) % 3 == 2) step(0, 0, 0, 0);
      else step($urandom_range(0, 9) < 4, $urandom_range(0, QD - 1),
                $urandom_range(0, 9) < 4, $urandom_range(0, QD - 1));
    end

    // drain
    rnd_fill = 1'b0;
    repeat (60) finish_heads();
    chk("R6", int'(exp_tag), int'(next_tag));
    chk("R5", int'(ren_free), NR);
    chk("R5", int'(cq_free), QD);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule